// File: doc/BRIEF.md
# Decoded sector buffer writer

This block takes sectors that have already been decoded and places them in a 16 KB circular byte buffer. A sector is presented as a 32-bit header on a one-beat header channel, followed by 2048 data bytes on a byte stream. The block keeps a copy of the most recent header, an active-low validity status byte and a decoder-event flag with an interrupt request. It also keeps two 16-bit pointers, a block pointer and a write address.

Two bits of a control byte govern each sector. Bit 7 enables decoding; while it is clear, an accepted header has no effect at all. Bit 2 requests storage; while it is clear, a decoded sector updates the header and status but nothing is written to memory. When storage is requested, both pointers move forward by 2352 even though only 2052 bytes are stored. The header and data are written starting at the low 14 bits of the new block pointer, and any byte past the top of the buffer continues at address 0.

Both inputs are valid/ready channels. A header is taken on a cycle where `hdr_valid` and `hdr_ready` are both high. `hdr_ready` is low for the whole time a sector is being stored, so a header offered then is held off and does not disturb the block. Data bytes are taken only while `data_ready` is high, which is only after the four header bytes have been written. The source may drop `data_valid` at any time to stall the stream. The RAM port has no back-pressure, and a write happens in every cycle where `ram_we` is high.

Top module: `sector_buf_writer`

## Requirements
- R1: After reset, `hdr_reg` is 0, `stat3` is 0x80, `dec_flag_n` is 1, `irq` is 0, `busy` is 0, `hdr_ready` is 1, `ram_we` is 0, and both pointers are 0.
- R2: A header accepted while `ctrl0[7]` is 0 changes nothing: `hdr_reg`, `stat3`, `dec_flag_n`, `irq` and both pointers keep their values, and no RAM write occurs.
- R3: A header accepted while `ctrl0[7]` is 1 is copied into `hdr_reg`, sets `stat3` to 0x00 and drives `dec_flag_n` low, all visible in the cycle after acceptance.
- R4: `irq` is high exactly when `dec_flag_n` is low and `irq_en` is high, and it follows `irq_en` within the same cycle.
- R5: When `ctrl0[7]` and `ctrl0[2]` are both 1, an accepted header adds 2352 to `blk_ptr` and to `wr_addr`, modulo 2^16.
- R6: Storage begins in the cycle after acceptance. The four header bytes are written in four consecutive cycles, most significant byte first, at base, base+1, base+2 and base+3, where base is the low 14 bits of the updated `blk_ptr`. `data_ready` stays low during those cycles.
- R7: Data byte n (0..2047) is written at base+4+n in the cycle it is accepted. A cycle without a handshake writes nothing, so exactly 2052 writes happen per stored sector.
- R8: All write addresses are taken modulo 16384, so bytes beyond 0x3FFF continue from 0x0000.
- R9: When `ctrl0[7]` is 1 and `ctrl0[2]` is 0, the header and status update as in R3, but there are no RAM writes, `busy` stays 0 and the pointers do not change.
- R10: A `stat_rd` pulse sets `stat3` to 0x80 and `dec_flag_n` to 1 in the next cycle. `hdr_reg` is not affected.
- R11: `busy` is high from the cycle after a storing header is accepted until the cycle after the last data byte is accepted. While it is high, `hdr_ready` is 0 and an offered header leaves `hdr_reg` unchanged.
- R12: `pt_load` and `wa_load` copy `load_val` into `blk_ptr` and `wr_addr` respectively while the block is idle. They are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl0 | input | 8 | Control byte: bit 7 enables decoding, bit 2 requests storage |
| irq_en | input | 1 | Decoder interrupt enable |
| hdr_valid | input | 1 | Header beat valid |
| hdr_ready | output | 1 | Header beat accepted when high |
| hdr_in | input | 32 | Sector header |
| data_valid | input | 1 | Data byte valid |
| data_ready | output | 1 | Data byte accepted when high |
| data_in | input | 8 | Data byte |
| stat_rd | input | 1 | Status read strobe; clears the pending flag |
| pt_load | input | 1 | Load `blk_ptr` from `load_val` |
| wa_load | input | 1 | Load `wr_addr` from `load_val` |
| load_val | input | 16 | Pointer load value |
| ram_we | output | 1 | Buffer write enable |
| ram_addr | output | 14 | Buffer byte address |
| ram_wdata | output | 8 | Buffer write data |
| busy | output | 1 | Sector storage in progress |
| hdr_reg | output | 32 | Last decoded header |
| stat3 | output | 8 | Validity status: 0x00 new sector, 0x80 none |
| dec_flag_n | output | 1 | Decoder event flag, low when pending |
| irq | output | 1 | Decoder interrupt request |
| blk_ptr | output | 16 | Block pointer |
| wr_addr | output | 16 | Write address |

## Verification
The bench drives sectors whose storage window straddles the top of the buffer. A writer that does not wrap would emit addresses past 0x3FFF, and one that wraps wrongly would put the wrapped tail somewhere other than address 0. It also uses a block pointer near 0xFFFF, which shows whether the 16-bit pointer wraps while the 14-bit base is still derived correctly. The data stream is stalled at irregular points, which exposes any design that writes on cycles without a handshake or drops a byte, because the write count or the byte contents would then be wrong. In the middle of a store, the bench offers a second header and a pointer load; a design without that hold-off would overwrite `hdr_reg` or move the pointer. It also checks the decode-off and store-off control settings, where a careless design would still write to the buffer or still change status.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HDR  = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_e;

  localparam logic [7:0] STAT_NONE  = 8'h80;
  localparam logic [7:0] STAT_FRESH = 8'h00;
endpackage

// File: rtl/sbw_status.sv
module sbw_status #(
  parameter int HDR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_go,
  input  logic [HDR_W-1:0] hdr_in,
  input  logic             stat_rd,
  input  logic             irq_en,
  output logic [HDR_W-1:0] hdr_reg,
  output logic [7:0]       stat3,
  output logic             dec_flag_n,
  output logic             irq
);
  import sbw_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_reg    <= '0;
      stat3      <= STAT_NONE;
      dec_flag_n <= 1'b1;
    end else if (dec_go) begin
      // a fresh sector outranks a simultaneous status read
      hdr_reg    <= hdr_in;
      stat3      <= STAT_FRESH;
      dec_flag_n <= 1'b0;
    end else if (stat_rd) begin
      stat3      <= STAT_NONE;
      dec_flag_n <= 1'b1;
    end
  end

  assign irq = irq_en && !dec_flag_n;
endmodule

// File: rtl/sbw_ptrs.sv
module sbw_ptrs #(
  parameter int PTR_W  = 16,
  parameter int BUF_AW = 14,
  parameter int STRIDE = 2352
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_go,
  input  logic              ld_allow,
  input  logic              pt_load,
  input  logic              wa_load,
  input  logic [PTR_W-1:0]  load_val,
  output logic [PTR_W-1:0]  blk_ptr,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BUF_AW-1:0] base_next
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(STRIDE);

  logic [PTR_W-1:0] pt_step;
  assign pt_step   = blk_ptr + STEP;
  assign base_next = pt_step[BUF_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_ptr <= '0;
      wr_addr <= '0;
    end else if (store_go) begin
      blk_ptr <= pt_step;
      wr_addr <= wr_addr + STEP;
    end else if (ld_allow) begin
      if (pt_load) blk_ptr <= load_val;
      if (wa_load) wr_addr <= load_val;
    end
  end
endmodule

// File: rtl/sbw_seq.sv
module sbw_seq #(
  parameter int BUF_AW     = 14,
  parameter int HDR_BYTES  = 4,
  parameter int DATA_BYTES = 2048
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   store_go,
  input  logic [BUF_AW-1:0]      base_in,
  input  logic [8*HDR_BYTES-1:0] hdr_in,
  input  logic                   data_valid,
  input  logic [7:0]             data_in,
  output logic                   data_ready,
  output logic                   ram_we,
  output logic [BUF_AW-1:0]      ram_addr,
  output logic [7:0]             ram_wdata,
  output logic                   busy
);
  import sbw_pkg::*;

  localparam int HDR_W = 8 * HDR_BYTES;
  localparam int TOTAL = HDR_BYTES + DATA_BYTES;
  localparam int CNT_W = $clog2(TOTAL);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] ALL_LAST = CNT_W'(TOTAL - 1);

  seq_state_e        state;
  logic [CNT_W-1:0]  idx;
  logic [BUF_AW-1:0] base_q;
  logic [HDR_W-1:0]  hdr_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      idx    <= '0;
      base_q <= '0;
      hdr_sh <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (store_go) begin
          base_q <= base_in;
          hdr_sh <= hdr_in;
          idx    <= '0;
          state  <= SEQ_HDR;
        end
        SEQ_HDR: begin
          hdr_sh <= hdr_sh << 8;
          idx    <= idx + 1'b1;
          if (idx == HDR_LAST) state <= SEQ_DATA;
        end
        SEQ_DATA: if (data_valid) begin
          idx <= idx + 1'b1;
          if (idx == ALL_LAST) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy       = (state != SEQ_IDLE);
  assign data_ready = (state == SEQ_DATA);
  assign ram_we     = (state == SEQ_HDR) || (data_ready && data_valid);
  assign ram_addr   = base_q + BUF_AW'(idx);
  assign ram_wdata  = (state == SEQ_HDR) ? hdr_sh[HDR_W-1 -: 8] : data_in;
endmodule

// File: rtl/sector_buf_writer.sv
module sector_buf_writer #(
  parameter int PTR_W      = 16,
  parameter int BUF_AW     = 14,
  parameter int HDR_BYTES  = 4,
  parameter int DATA_BYTES = 2048,
  parameter int STRIDE     = 2352,
  parameter int DEC_BIT    = 7,
  parameter int STORE_BIT  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             ctrl0,
  input  logic                   irq_en,
  input  logic                   hdr_valid,
  output logic                   hdr_ready,
  input  logic [8*HDR_BYTES-1:0] hdr_in,
  input  logic                   data_valid,
  output logic                   data_ready,
  input  logic [7:0]             data_in,
  input  logic                   stat_rd,
  input  logic                   pt_load,
  input  logic                   wa_load,
  input  logic [PTR_W-1:0]       load_val,
  output logic                   ram_we,
  output logic [BUF_AW-1:0]      ram_addr,
  output logic [7:0]             ram_wdata,
  output logic                   busy,
  output logic [8*HDR_BYTES-1:0] hdr_reg,
  output logic [7:0]             stat3,
  output logic                   dec_flag_n,
  output logic                   irq,
  output logic [PTR_W-1:0]       blk_ptr,
  output logic [PTR_W-1:0]       wr_addr
);
  localparam int HDR_W = 8 * HDR_BYTES;

  logic              take;
  logic              dec_go;
  logic              store_go;
  logic [BUF_AW-1:0] base_next;

  assign hdr_ready = !busy;
  assign take      = hdr_valid && hdr_ready;
  assign dec_go    = take && ctrl0[DEC_BIT];
  assign store_go  = dec_go && ctrl0[STORE_BIT];

  sbw_status #(.HDR_W(HDR_W)) u_status (
    .clk(clk), .rst_n(rst_n), .dec_go(dec_go), .hdr_in(hdr_in),
    .stat_rd(stat_rd), .irq_en(irq_en), .hdr_reg(hdr_reg),
    .stat3(stat3), .dec_flag_n(dec_flag_n), .irq(irq)
  );

  sbw_ptrs #(.PTR_W(PTR_W), .BUF_AW(BUF_AW), .STRIDE(STRIDE)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .store_go(store_go), .ld_allow(!busy),
    .pt_load(pt_load), .wa_load(wa_load), .load_val(load_val),
    .blk_ptr(blk_ptr), .wr_addr(wr_addr), .base_next(base_next)
  );

  sbw_seq #(.BUF_AW(BUF_AW), .HDR_BYTES(HDR_BYTES), .DATA_BYTES(DATA_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .store_go(store_go), .base_in(base_next),
    .hdr_in(hdr_in), .data_valid(data_valid), .data_in(data_in),
    .data_ready(data_ready), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .busy(busy)
  );
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
  parameter int PTR_W     = 16,
  parameter int HDR_W     = 32,
  parameter int STRIDE    = 2352,
  parameter int DEC_BIT   = 7,
  parameter int STORE_BIT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       ctrl0,
  input logic             hdr_valid,
  input logic             hdr_ready,
  input logic             data_ready,
  input logic             stat_rd,
  input logic             ram_we,
  input logic             busy,
  input logic [HDR_W-1:0] hdr_reg,
  input logic [7:0]       stat3,
  input logic             dec_flag_n,
  input logic [PTR_W-1:0] blk_ptr
);
  logic acc_store;
  logic acc_dec;
  assign acc_dec   = hdr_valid && hdr_ready && ctrl0[DEC_BIT];
  assign acc_store = acc_dec && ctrl0[STORE_BIT];

  AST_DEC_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && !ctrl0[DEC_BIT] && !stat_rd) |=> ($stable(stat3) && $stable(hdr_reg))); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_store |=> (blk_ptr == $past(blk_ptr) + PTR_W'(STRIDE))); // R5
  AST_STORE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_store |=> (busy && ram_we && !data_ready)); // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ram_we && !data_ready)); // R7
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !acc_dec) |=> (stat3 == 8'h80 && dec_flag_n)); // R10
  AST_BUSY_HOLD_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hdr_valid) |=> $stable(hdr_reg)); // R11
endmodule

bind sector_buf_writer sbw_checker #(
  .PTR_W(PTR_W), .HDR_W(8*HDR_BYTES), .STRIDE(STRIDE),
  .DEC_BIT(DEC_BIT), .STORE_BIT(STORE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl0(ctrl0), .hdr_valid(hdr_valid),
  .hdr_ready(hdr_ready), .data_ready(data_ready), .stat_rd(stat_rd),
  .ram_we(ram_we), .busy(busy), .hdr_reg(hdr_reg), .stat3(stat3),
  .dec_flag_n(dec_flag_n), .blk_ptr(blk_ptr)
);

// File: tb/tb_sector_buf_writer.sv
module tb_sector_buf_writer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  ctrl0 = 0;
  logic        irq_en = 0;
  logic        hdr_valid = 0;
  logic        hdr_ready;
  logic [31:0] hdr_in = 0;
  logic        data_valid = 0;
  logic        data_ready;
  logic [7:0]  data_in = 0;
  logic        stat_rd = 0;
  logic        pt_load = 0;
  logic        wa_load = 0;
  logic [15:0] load_val = 0;
  logic        ram_we;
  logic [13:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        busy;
  logic [31:0] hdr_reg;
  logic [7:0]  stat3;
  logic        dec_flag_n;
  logic        irq;
  logic [15:0] blk_ptr;
  logic [15:0] wr_addr;

  sector_buf_writer dut (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int          wcnt, werr, wwrap;
  logic [13:0] exp_base;
  logic [31:0] exp_hdr_w;

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 5) + (n >> 8) + 8'h3C);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // write monitor: compares every RAM write with the expected byte
  always @(negedge clk) begin
    #1;
    if (ram_we) begin
      logic [13:0] ea;
      logic [7:0]  ed;
      ea = 14'(exp_base + 14'(wcnt));
      ed = (wcnt < 4) ? exp_hdr_w[31 - 8*wcnt -: 8] : pat(wcnt - 4);
      if (ram_addr != ea || ram_wdata != ed) werr++;
      if (ram_addr < exp_base) wwrap++;
      wcnt++;
    end
  end

  task automatic stream(input bit inject);
    int sent = 0;
    int it = 0;
    bit did = 0;
    bit hs;
    while (sent < 2048) begin
      @(negedge clk);
      hdr_valid = 0; pt_load = 0;
      if (inject && sent == 1000 && !did) begin
        hdr_valid = 1; hdr_in = 32'h0BADF00D;
        pt_load = 1; load_val = 16'h7777; did = 1;
      end
      if ((it % 7) == 3) data_valid = 0;
      else begin data_valid = 1; data_in = pat(sent); end
      hs = data_valid && data_ready;
      it++;
      @(posedge clk);
      if (hs) sent++;
    end
    @(negedge clk);
    data_valid = 0; hdr_valid = 0; pt_load = 0;
    chk(!busy && hdr_ready, "R11 busy clears after last byte", {62'd0, busy, hdr_ready}, 64'h1);
  endtask

  task automatic send_sector(input logic [31:0] h, input bit wr, input logic [13:0] base, input bit inject);
    wcnt = 0; werr = 0; wwrap = 0; exp_base = base; exp_hdr_w = h;
    @(negedge clk); hdr_valid = 1; hdr_in = h;
    @(negedge clk); hdr_valid = 0;
    if (wr) begin
      chk(busy && ram_we && !data_ready, "R6 header phase start", {61'd0, busy, ram_we, data_ready}, 64'h6);
      chk(ram_addr == base, "R6 first header address", 64'(ram_addr), 64'(base));
      stream(inject);
    end else begin
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic load_ptrs(input logic [15:0] p, input logic [15:0] w);
    @(negedge clk); pt_load = 1; load_val = p;
    @(negedge clk); pt_load = 0; wa_load = 1; load_val = w;
    @(negedge clk); wa_load = 0;
  endtask

  task automatic pulse_rd;
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  typedef struct packed {
    logic [15:0] pt0;
    logic [7:0]  ctl;
    logic        ie;
    logic [31:0] hdr;
    logic [15:0] exp_pt;
    logic [31:0] exp_hdr;
    logic        exp_wr;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{16'h0000, 8'h84, 1'b1, 32'h00020174, 16'h0930, 32'h00020174, 1'b1},
    '{16'h3000, 8'h84, 1'b0, 32'h00031022, 16'h3930, 32'h00031022, 1'b1},
    '{16'h1234, 8'h80, 1'b0, 32'h11223344, 16'h1234, 32'h11223344, 1'b0},
    '{16'h2000, 8'h04, 1'b1, 32'hDEADBEEF, 16'h2000, 32'h11223344, 1'b0},
    '{16'hFA00, 8'h84, 1'b1, 32'h00995501, 16'h0330, 32'h00995501, 1'b1}
  };

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wcnt = 0; werr = 0; wwrap = 0; exp_base = 0; exp_hdr_w = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(hdr_reg == 0 && stat3 == 8'h80 && dec_flag_n && !irq, "R1 status reset",
        {hdr_reg, stat3, 22'd0, dec_flag_n, irq}, {32'd0, 8'h80, 22'd0, 2'b10});
    chk(!busy && hdr_ready && !ram_we && blk_ptr == 0 && wr_addr == 0, "R1 idle reset",
        {blk_ptr, wr_addr, 29'd0, busy, hdr_ready, ram_we}, 64'h2);

    for (int i = 0; i < 5; i++) begin
      vec_t v;
      logic [15:0] wa0;
      logic [15:0] exp_wa;
      bit dec;
      v = VEC[i];
      dec = v.ctl[7];
      wa0 = v.pt0 ^ 16'h0101;
      exp_wa = v.exp_wr ? 16'(wa0 + 16'd2352) : wa0;
      load_ptrs(v.pt0, wa0);
      chk(blk_ptr == v.pt0 && wr_addr == wa0, "R12 pointer load", {blk_ptr, wr_addr}, {v.pt0, wa0});
      pulse_rd();
      ctrl0 = v.ctl; irq_en = v.ie;
      send_sector(v.hdr, v.exp_wr, v.exp_pt[13:0], 1'b0);
      // R5/R9/R2 pointer results, R3/R2 header and status
      chk(blk_ptr == v.exp_pt && wr_addr == exp_wa, v.exp_wr ? "R5 pointer advance" : "R9 R2 pointers hold",
          {blk_ptr, wr_addr}, {v.exp_pt, exp_wa});
      chk(hdr_reg == v.exp_hdr, dec ? "R3 header latched" : "R2 header unchanged", 64'(hdr_reg), 64'(v.exp_hdr));
      chk(stat3 == (dec ? 8'h00 : 8'h80) && dec_flag_n == !dec, dec ? "R3 status fresh" : "R2 status unchanged",
          {stat3, 7'd0, dec_flag_n}, {(dec ? 8'h00 : 8'h80), 7'd0, !dec});
      chk(irq == (dec && v.ie), "R4 irq level", 64'(irq), 64'(dec && v.ie));
      chk(wcnt == (v.exp_wr ? 2052 : 0) && werr == 0, v.exp_wr ? "R7 R6 write stream" : "R9 R2 no writes",
          {32'(wcnt), 32'(werr)}, {32'(v.exp_wr ? 2052 : 0), 32'd0});
      if (i == 1) chk(wwrap == 308, "R8 wrapped tail count", 64'(wwrap), 64'd308);
      pulse_rd();
      chk(stat3 == 8'h80 && dec_flag_n && !irq && hdr_reg == v.exp_hdr, "R10 status read clears",
          {stat3, 6'd0, dec_flag_n, irq}, {8'h80, 8'h02});
    end

    // R11 / R12: header and load offered mid-store are ignored
    load_ptrs(16'h0000, 16'h0000);
    ctrl0 = 8'h84; irq_en = 1;
    send_sector(32'hCAFE0001, 1'b1, 14'h0930, 1'b1);
    chk(hdr_reg == 32'hCAFE0001, "R11 header held while busy", 64'(hdr_reg), 64'hCAFE0001);
    chk(blk_ptr == 16'h0930, "R12 load ignored while busy", 64'(blk_ptr), 64'h0930);
    chk(wcnt == 2052 && werr == 0, "R7 write stream with stalls", {32'(wcnt), 32'(werr)}, {32'd2052, 32'd0});

    // R4 irq follows enable immediately
    @(negedge clk); irq_en = 0; #1;
    chk(!irq, "R4 irq masked", 64'(irq), 64'd0);
    irq_en = 1; #1;
    chk(irq, "R4 irq unmasked", 64'(irq), 64'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule